// File: doc/BRIEF.md
# Eight-Channel Programmable Interval Timer Bank

This block holds eight independent down-counting timers behind a small byte-wide register port. Each timer has a 16-bit reload value, written one byte at a time. It counts down from that value on a shared prescaled tick-enable input. When it runs out, it raises a single expiry event. Each timer has one bit in each of three shared control bytes: a restart strobe, a run enable and an auto-reload selector.

Each expiry sets a sticky per-timer status flag. Software clears a flag by writing a one to it. A mask byte selects which flags drive the single combined interrupt line. A timer with auto-reload off stops after its expiry and stays silent until it is restarted. A timer with auto-reload on keeps expiring at a fixed number of ticks.

Top module: `timer_bank`

## Requirements
- R1: While `rst_n` is low, and after it rises, every stored byte, counter and status flag is zero and `irq` is low. No timer expires until it has been restarted.
- R2: Register map, with bit n of each byte belonging to timer n. Status is at 0x00, mask at 0x02, run enable at 0x0D and auto-reload at 0x0E. The low byte of timer n's reload value is at 0x10+2n and its high byte is at 0x11+2n. All of these read back what was last written.
- R3: Writing a one to bit n at 0x0C reloads timer n's counter from its reload value and arms the timer on the clock edge after the write. That address always reads 0. A restart outranks a tick that arrives in the same cycle.
- R4: A counter changes only on a clock edge where `tick` is 1 and its enable bit is 1, or on a restart. With enable 0, ticks leave the count untouched.
- R5: With auto-reload off and a reload value N of 1 or more, the timer expires on the Nth enabled tick after a restart. It then stays idle and gives no further expiry for any number of later ticks.
- R6: With auto-reload on and a reload value N of 1 or more, the timer expires on every Nth enabled tick.
- R7: A reload value of 0 expires on the first enabled tick. With auto-reload on, it expires on every enabled tick.
- R8: An expiry sets the timer's status flag on the edge that samples the expiring tick. The flag stays set until a write to 0x00 with a one in that bit. A zero in that bit has no effect. If a set and a clear land in the same cycle, the set wins.
- R9: `irq` is high exactly when some status flag and its mask bit are both 1. The mask has no effect on the status flags.
- R10: Reads of addresses not listed in R2 or R3 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Shared prescaled count enable |
| wr_en | input | 1 | Write strobe for the byte at `addr` |
| addr | input | 5 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| irq | output | 1 | Combined masked interrupt request |

## Verification
A register write takes effect on the edge that samples it. A restart bit reaches the counter one edge later, so it loads on the second edge after the write. An expiry sets its flag on the edge that samples the final tick, and `irq` and `rd_data` follow the stored state combinationally. The bench therefore drives every input at a falling edge and samples one falling edge after the edge in question. A restart written there is always followed by a full cycle before the next tick, except in the two directed cases that deliberately place a tick or a flag clear in the same cycle as a restart or an expiry.

// File: rtl/timer_bank.sv
module timer_bank #(
  parameter int NT = 8,
  parameter int IW = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  output logic          irq
);
  localparam int A_STAT = 0;
  localparam int A_MASK = 2;
  localparam int A_RST  = 12;
  localparam int A_EN   = 13;
  localparam int A_CONT = 14;
  localparam int A_IV   = 16;
  localparam int HW     = IW - 8;

  logic [NT-1:0] en_q, cont_q, mask_q, stat_q, rs_q, armed_q, exp_w, clr_w;
  logic [IW-1:0] ival_q [NT];
  logic [IW-1:0] cnt_q  [NT];

  wire w_stat = wr_en && (addr == AW'(A_STAT));
  wire w_mask = wr_en && (addr == AW'(A_MASK));
  wire w_rst  = wr_en && (addr == AW'(A_RST));
  wire w_en   = wr_en && (addr == AW'(A_EN));
  wire w_cont = wr_en && (addr == AW'(A_CONT));

  assign clr_w = w_stat ? wr_data[NT-1:0] : '0;
  assign irq   = |(stat_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      cont_q <= '0;
      mask_q <= '0;
      stat_q <= '0;
      rs_q   <= '0;
    end else begin
      if (w_en)   en_q   <= wr_data[NT-1:0];
      if (w_cont) cont_q <= wr_data[NT-1:0];
      if (w_mask) mask_q <= wr_data[NT-1:0];
      rs_q   <= w_rst ? wr_data[NT-1:0] : '0;
      stat_q <= (stat_q & ~clr_w) | exp_w;
    end
  end

  for (genvar n = 0; n < NT; n++) begin : g_tmr
    wire w_lo   = wr_en && (addr == AW'(A_IV + 2*n));
    wire w_hi   = wr_en && (addr == AW'(A_IV + 2*n + 1));
    wire at_end = cnt_q[n] <= IW'(1);
    wire run    = tick && en_q[n] && armed_q[n] && !rs_q[n];

    assign exp_w[n] = run && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ival_q[n] <= '0;
      else begin
        if (w_lo) ival_q[n][7:0]    <= wr_data;
        if (w_hi) ival_q[n][IW-1:8] <= wr_data[HW-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[n]   <= '0;
        armed_q[n] <= 1'b0;
      end else if (rs_q[n]) begin
        cnt_q[n]   <= ival_q[n];
        armed_q[n] <= 1'b1;
      end else if (run) begin
        if (!at_end)         cnt_q[n] <= cnt_q[n] - IW'(1);
        else if (cont_q[n])  cnt_q[n] <= ival_q[n];
        else begin
          cnt_q[n]   <= '0;
          armed_q[n] <= 1'b0;
        end
      end
    end

    p_restart_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rs_q[n] |=> cnt_q[n] == $past(ival_q[n]));

    p_hold_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[n] && !rs_q[n]) |=> $stable(cnt_q[n]));

    p_oneshot_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q[n] && !rs_q[n]) |=> (cnt_q[n] == '0 && !armed_q[n]));

    p_flag_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[n]) |-> $past(tick));
  end

  always_comb begin
    rd_data = '0;
    if (addr == AW'(A_STAT)) rd_data[NT-1:0] = stat_q;
    if (addr == AW'(A_MASK)) rd_data[NT-1:0] = mask_q;
    if (addr == AW'(A_EN))   rd_data[NT-1:0] = en_q;
    if (addr == AW'(A_CONT)) rd_data[NT-1:0] = cont_q;
    for (int n = 0; n < NT; n++) begin
      if (addr == AW'(A_IV + 2*n))     rd_data          = ival_q[n][7:0];
      if (addr == AW'(A_IV + 2*n + 1)) rd_data[HW-1:0] = ival_q[n][IW-1:8];
    end
  end

  p_restart_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(A_RST)) |-> rd_data == 8'h00);

  p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask_q != '0);

  p_irq_after_reset_r1: assert property (@(posedge clk)
    !rst_n |-> !irq);
endmodule

// File: tb/timer_bank_tb_top.sv
`timescale 1ns/1ps
module timer_bank_tb_top;
  localparam int A_STAT = 0, A_MASK = 2, A_RST = 12, A_EN = 13, A_CONT = 14, A_IV = 16;

  // fields: timer(3) reload(16) autoreload(1) ticks(9) expected_count(8) expected_first(9)
  localparam logic [45:0] VEC [0:7] = '{
    {3'd0, 16'd5,   1'b0, 9'd12,  8'd1, 9'd5},
    {3'd1, 16'd3,   1'b1, 9'd10,  8'd3, 9'd3},
    {3'd2, 16'd0,   1'b0, 9'd4,   8'd1, 9'd1},
    {3'd3, 16'd0,   1'b1, 9'd5,   8'd5, 9'd1},
    {3'd4, 16'd7,   1'b0, 9'd6,   8'd0, 9'd0},
    {3'd5, 16'd256, 1'b0, 9'd256, 8'd1, 9'd256},
    {3'd6, 16'd4,   1'b1, 9'd16,  8'd4, 9'd4},
    {3'd7, 16'd1,   1'b1, 9'd3,   8'd3, 9'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, irq;
  logic [4:0] addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  timer_bank dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
                    .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = a[4:0]; wr_data = d[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr = a[4:0];
    #1;
    d = int'(rd_data);
  endtask

  task automatic tk();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R1 irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    foreach (VEC[i]) begin
      logic [45:0] v;
      int t, iv, nt, cnt, first;
      v = VEC[i];
      t = int'(v[45:43]); iv = int'(v[42:27]); nt = int'(v[25:17]);
      wr(A_IV + 2*t, iv & 255);
      wr(A_IV + 2*t + 1, iv >> 8);
      wr(A_CONT, int'(v[26]) << t);
      wr(A_MASK, 1 << t);
      wr(A_EN, 1 << t);
      wr(A_RST, 1 << t);
      cnt = 0; first = 0;
      for (int k = 1; k <= nt; k++) begin
        tk();
        if (irq) begin
          cnt++;
          if (first == 0) first = k;
          wr(A_STAT, 8'hFF);
        end
      end
      chk(cnt == int'(v[16:9]), v[26] ? "R6/R7 expiry count" : "R5/R7 expiry count", cnt, int'(v[16:9]));
      chk(first == int'(v[8:0]), "R5/R6/R7 first expiry tick", first, int'(v[8:0]));
      wr(A_EN, 0);
    end

    // R2 readback and R10 undefined address
    wr(A_EN, 8'hA5); rd(A_EN, d); chk(d == 8'hA5, "R2 enable readback", d, 8'hA5);
    wr(A_CONT, 8'h3C); rd(A_CONT, d); chk(d == 8'h3C, "R2 autoreload readback", d, 8'h3C);
    wr(A_IV + 7, 8'h12); rd(A_IV + 7, d); chk(d == 8'h12, "R2 timer3 high byte", d, 8'h12);
    rd(5, d); chk(d == 0, "R10 undefined read", d, 0);
    wr(A_RST, 8'hFF); rd(A_RST, d); chk(d == 0, "R3 restart reads zero", d, 0);

    // R1 reset clears everything
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rd(A_EN, d); chk(d == 0, "R1 enable cleared", d, 0);
    rd(A_IV + 7, d); chk(d == 0, "R1 reload cleared", d, 0);
    rst_n = 1'b1;
    wr(A_EN, 8'hFF); wr(A_MASK, 8'hFF);
    repeat (4) tk();
    chk(irq == 1'b0, "R1 idle until restart", int'(irq), 0);
    rd(A_STAT, d); chk(d == 0, "R1 no status after reset", d, 0);

    // R4 enable gating
    wr(A_EN, 0); wr(A_MASK, 1); wr(A_CONT, 0);
    wr(A_IV, 2); wr(A_RST, 1);
    repeat (5) tk();
    chk(irq == 1'b0, "R4 disabled ticks ignored", int'(irq), 0);
    wr(A_EN, 1);
    tk(); chk(irq == 1'b0, "R4 count held at reload", int'(irq), 0);
    tk(); chk(irq == 1'b1, "R4 expires after enable", int'(irq), 1);

    // R9 mask, R8 write-zero and write-one
    wr(A_MASK, 0);
    chk(irq == 1'b0, "R9 masked flag", int'(irq), 0);
    rd(A_STAT, d); chk(d == 1, "R9 flag kept while masked", d, 1);
    wr(A_STAT, 0); rd(A_STAT, d); chk(d == 1, "R8 zero write no effect", d, 1);
    wr(A_MASK, 1); chk(irq == 1'b1, "R9 unmasked flag", int'(irq), 1);
    wr(A_STAT, 1); chk(irq == 1'b0, "R8 write one clears", int'(irq), 0);
    repeat (3) tk();
    chk(irq == 1'b0, "R5 stays idle after expiry", int'(irq), 0);

    // R3 restart mid-count
    wr(A_IV, 4); wr(A_RST, 1);
    repeat (3) tk();
    wr(A_RST, 1);
    repeat (3) tk();
    chk(irq == 1'b0, "R3 mid-count restart reloads", int'(irq), 0);
    tk(); chk(irq == 1'b1, "R3 expiry after reload", int'(irq), 1);
    wr(A_STAT, 1);

    // R3 restart outranks tick in its strobe cycle
    wr(A_RST, 1);
    repeat (3) tk();
    @(negedge clk); wr_en = 1'b1; addr = 5'(A_RST); wr_data = 8'h01;
    @(negedge clk); wr_en = 1'b0; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk(irq == 1'b0, "R3 restart beats tick", int'(irq), 0);
    repeat (3) tk();
    chk(irq == 1'b0, "R3 full interval after collision", int'(irq), 0);
    tk(); chk(irq == 1'b1, "R3 expiry after collision", int'(irq), 1);
    wr(A_STAT, 1);

    // R8 set outranks clear in the same cycle
    wr(A_RST, 1);
    repeat (3) tk();
    @(negedge clk); wr_en = 1'b1; addr = 5'(A_STAT); wr_data = 8'h01; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    rd(A_STAT, d); chk(d == 1, "R8 set wins over clear", d, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule